// File: doc/BRIEF.md
# Quarter-Wave Direct Digital Sine Synthesizer

This block generates a sine wave numerically. On every clock, a 24-bit phase register advances by a 9-bit tuning word. A static 11-bit phase offset is then added, aligned to the most significant end of the phase. Only the top 13 bits of the offset phase are kept, and they form the lookup phase. At the default 15 MHz clock, one tuning step moves the output frequency by 15e6/2^24 Hz, which is about 0.894 Hz. One offset step turns the waveform by 360/2048 degrees.

The sine table stores only the first quarter of a period. The rest of the period is rebuilt from that quarter. The second lookup bit folds the table address back on itself, and the top lookup bit negates the fetched amplitude. The table contents are computed during elaboration, so no external file is read. A single register follows the lookup, and the block returns one signed sample per clock. The lookup phase is also available as a port, so that neighbouring logic can watch where the wave is.

Top module: `dds_qsine`

## Requirements
- R1: A synchronous reset clears the phase register to zero and the sample output to zero. While reset is held, `phase_o` equals `pcw_i` shifted left by 2.
- R2: On each clock edge without reset, the phase register grows by `fcw_i` (zero-extended), wrapping modulo 2^24.
- R3: `phase_o` is bits 23:11 of (phase register + `pcw_i`·2^13) mod 2^24. It is combinational from the phase register and `pcw_i`.
- R4: Table entry i (i = 0..2047) holds round(255·sin((i+0.5)·π/4096)).
- R5: When `phase_o[11]` is 1, the table is read at address ~`phase_o[10:0]`. Otherwise it is read at `phase_o[10:0]`.
- R6: When `phase_o[12]` is 1, the sample is the negated table entry. Otherwise it is the entry itself. The sample is 9-bit two's complement and never reaches -256.
- R7: `sample_o` after a clock edge corresponds to the `phase_o` value present just before that edge, giving one cycle of latency.
- R8: Corner values: lookup phase 0 gives 0, 1024 gives 180, 2048 gives 255, 3072 gives 180, 4096 gives 0, 5120 gives -180, 6144 gives -255, and 8188 gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_i | input | 9 | Tuning word added to the phase every clock |
| pcw_i | input | 11 | Static phase offset, one step = 1/2048 turn |
| phase_o | output | 13 | Lookup phase: sign bit, fold bit, table address |
| sample_o | output | 9 | Signed sine sample, registered |

## Verification
The bench builds the block with its default parameters: a 24-bit phase, a 2048-entry table of 8-bit amplitudes, and the half-sample table offset. With these values the corner amplitudes of 0, ±180 and ±255 are exact integers that can be checked by hand. A ramp at the largest tuning word covers more than one full turn of the 24-bit phase, so the wrap of the phase register and every quadrant boundary are all reached in about 33,000 cycles. A second ramp with a nonzero offset checks that the offset is added after accumulation.

// File: rtl/dds_qsine_pkg.sv
package dds_qsine_pkg;

   localparam real PI = 3.14159265358979323846;

   // Amplitude of quarter-wave entry idx for a table of 2**aw entries.
   function automatic int quarter_sine(input int idx, input int aw,
                                       input int dw, input real ofs);
      real ang;
      real full;
      ang  = ((real'(idx) + ofs) * PI / 2.0) / real'(1 << aw);
      full = real'((1 << dw) - 1);
      return int'(full * $sin(ang));
   endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 24,
   parameter int FCW_W = 9,
   parameter int PCW_W = 11,
   parameter int LKP_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [FCW_W-1:0] fcw,
   input  logic [PCW_W-1:0] pcw,
   output logic [LKP_W-1:0] lkp_phase
);
   localparam int SHIFT = ACC_W - PCW_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] offset;
   logic [ACC_W-1:0] shifted;

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + ACC_W'(fcw);
   end

   generate
      if (SHIFT > 0) begin : g_align
         assign offset = {pcw, {SHIFT{1'b0}}};
      end else begin : g_flush
         assign offset = pcw;
      end
   endgenerate

   assign shifted   = acc_q + offset;
   assign lkp_phase = shifted[ACC_W-1 -: LKP_W];
endmodule

// File: rtl/dds_quadrant_map.sv
module dds_quadrant_map #(
   parameter int LUT_AW = 11
) (
   input  logic [LUT_AW+1:0] lkp_phase,
   output logic [LUT_AW-1:0] lut_addr,
   output logic              negate
);
   logic fold;

   assign fold     = lkp_phase[LUT_AW];
   assign negate   = lkp_phase[LUT_AW+1];
   assign lut_addr = fold ? ~lkp_phase[LUT_AW-1:0] : lkp_phase[LUT_AW-1:0];
endmodule

// File: rtl/dds_quarter_lut.sv
module dds_quarter_lut #(
   parameter int LUT_AW      = 11,
   parameter int AMP_W       = 8,
   parameter bit HALF_SAMPLE = 1'b1
) (
   input  logic [LUT_AW-1:0] addr,
   output logic [AMP_W-1:0]  amp
);
   localparam int  DEPTH = 1 << LUT_AW;
   localparam real OFS   = HALF_SAMPLE ? 0.5 : 0.0;

   logic [AMP_W-1:0] rom [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_rom
         localparam int VAL = dds_qsine_pkg::quarter_sine(i, LUT_AW, AMP_W, OFS);
         assign rom[i] = AMP_W'(VAL);
      end
   endgenerate

   assign amp = rom[addr];
endmodule

// File: rtl/dds_qsine.sv
module dds_qsine #(
   parameter int ACC_W       = 24,
   parameter int FCW_W       = 9,
   parameter int PCW_W       = 11,
   parameter int LUT_AW      = 11,
   parameter int AMP_W       = 8,
   parameter bit HALF_SAMPLE = 1'b1,
   localparam int LKP_W      = LUT_AW + 2,
   localparam int OUT_W      = AMP_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [FCW_W-1:0] fcw_i,
   input  logic [PCW_W-1:0] pcw_i,
   output logic [LKP_W-1:0] phase_o,
   output logic [OUT_W-1:0] sample_o
);
   generate
      if (ACC_W < LKP_W) begin : g_bad_acc
         $error("phase register narrower than lookup phase");
      end
      if (PCW_W > ACC_W) begin : g_bad_pcw
         $error("phase offset wider than phase register");
      end
      if (FCW_W >= ACC_W) begin : g_bad_fcw
         $error("tuning word must be narrower than phase register");
      end
   endgenerate

   logic [LUT_AW-1:0] lut_addr;
   logic              negate;
   logic [AMP_W-1:0]  amp;
   logic [OUT_W-1:0]  amp_ext;
   logic [OUT_W-1:0]  sample_d;

   dds_phase_acc #(
      .ACC_W(ACC_W), .FCW_W(FCW_W), .PCW_W(PCW_W), .LKP_W(LKP_W)
   ) u_acc (
      .clk(clk), .rst(rst), .fcw(fcw_i), .pcw(pcw_i), .lkp_phase(phase_o)
   );

   dds_quadrant_map #(.LUT_AW(LUT_AW)) u_map (
      .lkp_phase(phase_o), .lut_addr(lut_addr), .negate(negate)
   );

   dds_quarter_lut #(
      .LUT_AW(LUT_AW), .AMP_W(AMP_W), .HALF_SAMPLE(HALF_SAMPLE)
   ) u_lut (
      .addr(lut_addr), .amp(amp)
   );

   assign amp_ext  = {1'b0, amp};
   assign sample_d = negate ? (~amp_ext + 1'b1) : amp_ext;

   always_ff @(posedge clk) begin
      if (rst) sample_o <= '0;
      else     sample_o <= sample_d;
   end
endmodule

// File: rtl/dds_qsine_chk.sv
module dds_qsine_chk #(
   parameter int FCW_W = 9,
   parameter int PCW_W = 11,
   parameter int LKP_W = 13,
   parameter int AMP_W = 8,
   parameter int OUT_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic [FCW_W-1:0] fcw_i,
   input logic [PCW_W-1:0] pcw_i,
   input logic [LKP_W-1:0] phase_o,
   input logic [OUT_W-1:0] sample_o
);
   localparam logic [LKP_W-1:0] PEAK_PH   = LKP_W'(1) << (LKP_W - 2);
   localparam logic [LKP_W-1:0] TROUGH_PH = PEAK_PH * 3;
   localparam logic [OUT_W-1:0] PEAK      = OUT_W'((1 << AMP_W) - 1);
   localparam logic [OUT_W-1:0] MOST_NEG  = OUT_W'(1) << (OUT_W - 1);

   AST_FROZEN_PHASE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(fcw_i) == '0 && $stable(pcw_i)) |-> $stable(phase_o)); // R3
   AST_UPPER_NONNEG: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(phase_o[LKP_W-1])) |-> !sample_o[OUT_W-1]); // R6
   AST_LOWER_NONPOS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(phase_o[LKP_W-1])) |-> ($signed(sample_o) <= 0)); // R6
   AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
      sample_o != MOST_NEG); // R6
   AST_QUARTER_PEAK: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(phase_o) == PEAK_PH) |-> sample_o == PEAK); // R8
   AST_QUARTER_TROUGH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(phase_o) == TROUGH_PH) |-> sample_o == (~PEAK + 1'b1)); // R8
endmodule

bind dds_qsine dds_qsine_chk #(
   .FCW_W(FCW_W), .PCW_W(PCW_W), .LKP_W(LKP_W), .AMP_W(AMP_W), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst(rst), .fcw_i(fcw_i), .pcw_i(pcw_i),
   .phase_o(phase_o), .sample_o(sample_o)
);

// File: tb/dds_qsine_tb.sv
module dds_qsine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   typedef struct packed {
      logic [10:0]        pcw;
      logic [12:0]        ph;
      logic signed [8:0]  smp;
   } vec_t;

   // fcw = 0 after reset: phase register stays 0, phase_o = pcw<<2 (R3, R8)
   localparam vec_t VEC [NVEC] = '{
      '{pcw: 11'd0,    ph: 13'd0,    smp:  9'sd0},
      '{pcw: 11'd256,  ph: 13'd1024, smp:  9'sd180},
      '{pcw: 11'd512,  ph: 13'd2048, smp:  9'sd255},
      '{pcw: 11'd768,  ph: 13'd3072, smp:  9'sd180},
      '{pcw: 11'd1024, ph: 13'd4096, smp:  9'sd0},
      '{pcw: 11'd1280, ph: 13'd5120, smp: -9'sd180},
      '{pcw: 11'd1536, ph: 13'd6144, smp: -9'sd255},
      '{pcw: 11'd2047, ph: 13'd8188, smp: -9'sd1}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [8:0]  fcw_i = '0;
   logic [10:0] pcw_i = '0;
   logic [12:0] phase_o;
   logic [8:0]  sample_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dds_qsine u_dut (
      .clk(clk), .rst(rst), .fcw_i(fcw_i), .pcw_i(pcw_i),
      .phase_o(phase_o), .sample_o(sample_o)
   );

   // Expected sample from R4, R5, R6
   function automatic logic signed [8:0] ref_sample(input logic [12:0] ph);
      logic [10:0] a;
      int v;
      a = ph[11] ? ~ph[10:0] : ph[10:0];
      v = int'(255.0 * $sin((real'(a) + 0.5) * 3.14159265358979323846 / 4096.0));
      return ph[12] ? 9'(-v) : 9'(v);
   endfunction

   function automatic logic [12:0] ref_phase(input logic [23:0] acc, input logic [10:0] pcw);
      logic [23:0] s;
      s = acc + {pcw, 13'd0};
      return s[23:11];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic ramp(input logic [8:0] f, input logic [10:0] p, input int n);
      logic [23:0] acc_m;
      logic [12:0] prev;
      do_reset();
      fcw_i = f; pcw_i = p; acc_m = '0;
      #1;
      for (int k = 0; k < n; k++) begin
         prev = ref_phase(acc_m, p);
         check("R3 phase", int'(phase_o), int'(prev));
         @(posedge clk); @(negedge clk);
         acc_m = acc_m + 24'(f);                            // R2
         check("R7 sample", int'($signed(sample_o)), int'(ref_sample(prev)));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      pcw_i = 11'd300;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 sample", int'(sample_o), 0);
      check("R1 phase", int'(phase_o), 300 * 4);
      rst = 1'b0;

      // R8 / R5 / R6: vector table with fcw = 0
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         pcw_i = VEC[v].pcw;
         #1;
         check("R3 vec phase", int'(phase_o), int'(VEC[v].ph));
         @(posedge clk); @(negedge clk);
         check("R8 vec sample", int'($signed(sample_o)), int'(VEC[v].smp));
         check("R2 fcw zero holds", int'(phase_o), int'(VEC[v].ph));
      end

      // R4: first entry and mirror symmetry
      check("R4 entry0", int'(ref_sample(13'd0)), 0);
      check("R5 mirror", int'(ref_sample(13'd2048 + 13'd5)), int'(ref_sample(13'd2047 - 13'd5)));

      // R2, R7: full-turn ramp with wrap, then with an offset
      ramp(9'd511, 11'd0, 33000);
      ramp(9'd77, 11'd1500, 3000);

      // R1: reset mid-run clears phase register and sample
      @(negedge clk); rst = 1'b1; pcw_i = 11'd5;
      @(posedge clk); @(negedge clk);
      check("R1 midrun sample", int'(sample_o), 0);
      check("R1 midrun phase", int'(phase_o), 20);
      rst = 1'b0; fcw_i = '0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule